// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block is a purely combinational predicate evaluator for two operands held in a sign-magnitude binary floating-point format. A 3-bit operation code picks one of eight tests: four relational ones (below, below-or-same, above, above-or-same), equality and inequality, and two tests of whether the pair is ordered. The one-bit answer is meant to be zero-extended into the low bit of a wider result word by the enclosing unit. A separate flag reports that at least one operand is not a number.

A single width parameter sets the total word size. The exponent and fraction widths are derived from it. The sign sits in the most significant bit, the exponent directly below it, and the fraction below that. No clock is involved: a change on any input shows up at both outputs within the same combinational evaluation.

Top module: `fpcmp_unit`

## Requirements
- R1: The op code selects the predicate as follows: 0 below, 1 below-or-same, 2 above, 3 above-or-same, 4 equal, 5 not equal, 6 ordered, 7 unordered. For two non-NaN operands, exactly one of below, equal and above holds, and the result follows real-number ordering.
- R2: `nan_flag` is 1 exactly when either operand has an exponent field of all ones and a non-zero fraction field. It does not depend on `op`.
- R3: An exponent of all ones with a zero fraction is an infinity. It does not raise `nan_flag`, and it orders above every finite value of its sign (positive infinity is the largest value, negative infinity the smallest).
- R4: When either operand is NaN, ops 0 to 4 return 0 and op 5 returns 1.
- R5: Op 6 returns 1 only when neither operand is NaN. Op 7 returns 1 only when at least one operand is NaN.
- R6: Positive zero and negative zero compare as equal to each other and to themselves.
- R7: When the signs differ (and the operands are not both zero), the negative operand is the smaller one. When both operands are negative, a larger magnitude means a smaller value.
- R8: Denormal operands (exponent field 0, fraction non-zero) are ordered by magnitude like any other finite value.
- R9: The width W sets the exponent/fraction split: 80→15/64, 64→11/52, 52→11/40, 48→11/36, 44→11/32, 42→11/30, 40→10/29, 32→8/23, 24→7/16. Any other width uses 5/10, taken from the top 16 bits.
- R10: Both outputs follow an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 3 | Predicate select code (see R1) |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | 1 | Predicate value |
| nan_flag | output | 1 | High when either operand is NaN |

## Verification
The embedded assertions are evaluated on every input change. They check that a non-NaN pair always falls into exactly one of the three relations, that a NaN forces ops 0 to 4 low and op 5 high, that ops 6 and 7 mirror the NaN flag, that two zeros are reported equal, and that an infinity is never classified as NaN. The actual ordering of values cannot be shown by these assertions: negative-pair inversion, denormal ordering, infinity as an extreme, and the field split for each width are only shown by the bench. It sweeps every pair of corner operands and random operands at 32 and 64 bits, through all eight codes, against an independent key-based reference.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    CMP_LT    = 3'd0,
    CMP_LE    = 3'd1,
    CMP_GT    = 3'd2,
    CMP_GE    = 3'd3,
    CMP_EQ    = 3'd4,
    CMP_NE    = 3'd5,
    CMP_ORD   = 3'd6,
    CMP_UNORD = 3'd7
  } cmp_op_e;

  // exponent field width for a given total width
  function automatic int exp_width(input int w);
    case (w)
      80:                 return 15;
      64, 52, 48, 44, 42: return 11;
      40:                 return 10;
      32:                 return 8;
      24:                 return 7;
      default:            return 5;
    endcase
  endfunction

  // fraction field width for a given total width
  function automatic int frac_width(input int w);
    case (w)
      80:      return 64;
      64:      return 52;
      52:      return 40;
      48:      return 36;
      44:      return 32;
      42:      return 30;
      40:      return 29;
      32:      return 23;
      24:      return 16;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/fpcmp_decode.sv
module fpcmp_decode #(
  parameter int W  = 32,
  parameter int EB = 8,
  parameter int FB = 23,
  localparam int MW = EB + FB
) (
  input  logic [W-1:0]  x,
  output logic          sign,
  output logic [MW-1:0] mag,
  output logic          is_nan,
  output logic          is_zero
);

  logic [EB-1:0] expo;
  logic [FB-1:0] frac;
  logic          exp_full;
  logic          frac_nz;

  assign sign     = x[W-1];
  assign expo     = x[W-2 -: EB];
  assign frac     = x[W-2-EB -: FB];
  assign exp_full = &expo;
  assign frac_nz  = |frac;
  assign mag      = {expo, frac};
  assign is_nan   = exp_full & frac_nz;
  assign is_zero  = (mag == '0);

  always_comb begin
    if (exp_full && !frac_nz)
      AST_INF_NOT_NAN: assert (!is_nan && !is_zero); // R3
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int MW = 31
) (
  input  logic          sa,
  input  logic          sb,
  input  logic [MW-1:0] ma,
  input  logic [MW-1:0] mb,
  input  logic          za,
  input  logic          zb,
  output logic          lt,
  output logic          eq,
  output logic          gt
);

  logic mag_lt;
  logic mag_eq;

  assign mag_lt = (ma < mb);
  assign mag_eq = (ma == mb);

  always_comb begin
    lt = 1'b0;
    eq = 1'b0;
    gt = 1'b0;
    if (za && zb) begin
      eq = 1'b1;
    end else if (sa != sb) begin
      lt = sa;
      gt = sb;
    end else if (!sa) begin
      lt = mag_lt;
      eq = mag_eq;
      gt = !mag_lt && !mag_eq;
    end else begin
      lt = !mag_lt && !mag_eq;
      eq = mag_eq;
      gt = mag_lt;
    end
  end

  always_comb begin
    if (za && zb)
      AST_ZEROS_EQUAL: assert (eq && !lt && !gt); // R6
    if (sa && !sb && !(za && zb))
      AST_NEG_BELOW_POS: assert (lt); // R7
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit #(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         result,
  output logic         nan_flag
);
  import fpcmp_pkg::*;

  localparam int EB = exp_width(W);
  localparam int FB = frac_width(W);
  localparam int MW = EB + FB;

  logic          sign_a, sign_b;
  logic [MW-1:0] mag_a, mag_b;
  logic          nan_a, nan_b;
  logic          zero_a, zero_b;
  logic          rel_lt, rel_eq, rel_gt;
  logic          any_nan;
  logic          is_lt, is_eq, is_gt;

  fpcmp_decode #(.W(W), .EB(EB), .FB(FB)) u_dec_a (
    .x(a), .sign(sign_a), .mag(mag_a), .is_nan(nan_a), .is_zero(zero_a)
  );

  fpcmp_decode #(.W(W), .EB(EB), .FB(FB)) u_dec_b (
    .x(b), .sign(sign_b), .mag(mag_b), .is_nan(nan_b), .is_zero(zero_b)
  );

  fpcmp_order #(.MW(MW)) u_order (
    .sa(sign_a), .sb(sign_b), .ma(mag_a), .mb(mag_b),
    .za(zero_a), .zb(zero_b),
    .lt(rel_lt), .eq(rel_eq), .gt(rel_gt)
  );

  assign any_nan  = nan_a | nan_b;
  assign nan_flag = any_nan;
  assign is_lt    = rel_lt & ~any_nan;
  assign is_eq    = rel_eq & ~any_nan;
  assign is_gt    = rel_gt & ~any_nan;

  always_comb begin
    case (cmp_op_e'(op))
      CMP_LT:    result = is_lt;
      CMP_LE:    result = is_lt | is_eq;
      CMP_GT:    result = is_gt;
      CMP_GE:    result = is_gt | is_eq;
      CMP_EQ:    result = is_eq;
      CMP_NE:    result = ~is_eq;
      CMP_ORD:   result = ~any_nan;
      CMP_UNORD: result = any_nan;
      default:   result = 1'b0;
    endcase
  end

  always_comb begin
    if (!any_nan)
      AST_ONE_RELATION: assert ($onehot({rel_lt, rel_eq, rel_gt})); // R1
    if (nan_flag && op <= 3'd4)
      AST_NAN_FALSE: assert (!result); // R4
    if (nan_flag && op == 3'd5)
      AST_NAN_NE_TRUE: assert (result); // R4
    if (op == 3'd6)
      AST_ORD_MIRROR: assert (result == !nan_flag); // R5
    if (op == 3'd7)
      AST_UNORD_MIRROR: assert (result == nan_flag); // R5
  end

endmodule

// File: tb/fpcmp_unit_tb.sv
module fpcmp_unit_tb;

  typedef struct {
    int          w;
    logic [2:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic        res;
    logic        nan;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op32 = '0, op64 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] a64 = '0, b64 = '0;
  logic        r32, n32, r64, n64;
  int          tests = 0;
  int          failed = 0;
  bit          done = 1'b0;
  item_t       q[$];

  always #4 clk = ~clk;

  fpcmp_unit #(.W(32)) u_dut (
    .op(op32), .a(a32), .b(b32), .result(r32), .nan_flag(n32)
  );

  fpcmp_unit #(.W(64)) u_dut_w64 (
    .op(op64), .a(a64), .b(b64), .result(r64), .nan_flag(n64)
  );

  function automatic int fw_of(input int w);
    return (w == 32) ? 23 : 52;
  endfunction

  function automatic int ew_of(input int w);
    return (w == 32) ? 8 : 11;
  endfunction

  function automatic logic [63:0] mk(input int w, input bit s,
                                     input logic [63:0] e, input logic [63:0] f);
    return ({63'd0, s} << (w - 1)) | (e << fw_of(w)) | f;
  endfunction

  function automatic bit ref_nan(input int w, input logic [63:0] x);
    logic [63:0] m, e, f;
    m = x & ((64'd1 << (w - 1)) - 64'd1);
    e = m >> fw_of(w);
    f = m & ((64'd1 << fw_of(w)) - 64'd1);
    return (e == ((64'd1 << ew_of(w)) - 64'd1)) && (f != 0);
  endfunction

  // order-preserving key: zero magnitudes of both signs map to the same key
  function automatic logic [63:0] key_of(input int w, input logic [63:0] x);
    logic [63:0] m;
    m = x & ((64'd1 << (w - 1)) - 64'd1);
    return x[w-1] ? (64'h8000_0000_0000_0000 - m) : (64'h8000_0000_0000_0000 + m);
  endfunction

  function automatic bit ref_res(input int w, input logic [2:0] op,
                                 input logic [63:0] a, input logic [63:0] b);
    bit nn;
    logic [63:0] ka, kb;
    nn = ref_nan(w, a) || ref_nan(w, b);
    ka = key_of(w, a);
    kb = key_of(w, b);
    case (op)
      3'd0: return !nn && (ka < kb);
      3'd1: return !nn && (ka <= kb);
      3'd2: return !nn && (ka > kb);
      3'd3: return !nn && (ka >= kb);
      3'd4: return !nn && (ka == kb);
      3'd5: return nn || (ka != kb);
      3'd6: return !nn;
      default: return nn;
    endcase
  endfunction

  function automatic string tag_of(input int w, input logic [2:0] op,
                                   input logic [63:0] a, input logic [63:0] b);
    logic [63:0] m, ea, eb, ma, mb;
    m  = (64'd1 << (w - 1)) - 64'd1;
    ma = a & m;
    mb = b & m;
    ea = ma >> fw_of(w);
    eb = mb >> fw_of(w);
    if (ref_nan(w, a) || ref_nan(w, b)) return (op >= 3'd6) ? "R5" : "R4";
    if (ma == 0 && mb == 0) return "R6";
    if (ea == ((64'd1 << ew_of(w)) - 64'd1) || eb == ((64'd1 << ew_of(w)) - 64'd1)) return "R3";
    if ((ea == 0 && ma != 0) || (eb == 0 && mb != 0)) return "R8";
    if (a[w-1] || b[w-1]) return "R7";
    return "R1";
  endfunction

  task automatic drive(input int w, input logic [2:0] op,
                       input logic [63:0] a, input logic [63:0] b);
    item_t it;
    @(posedge clk);
    #1;
    if (w == 32) begin
      op32 = op; a32 = a[31:0]; b32 = b[31:0];
    end else begin
      op64 = op; a64 = a; b64 = b;
    end
    it.w = w; it.op = op; it.a = a; it.b = b;
    it.res = ref_res(w, op, a, b);
    it.nan = ref_nan(w, a) || ref_nan(w, b);
    it.tag = tag_of(w, op, a, b);
    q.push_back(it);
  endtask

  task automatic all_ops(input int w, input logic [63:0] a, input logic [63:0] b);
    for (int k = 0; k < 8; k++) drive(w, 3'(k), a, b);
  endtask

  // monitor: pops expectations and compares them at the falling edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      logic gr, gn;
      it = q.pop_front();
      gr = (it.w == 32) ? r32 : r64;
      gn = (it.w == 32) ? n32 : n64;
      tests++;
      if (gr !== it.res) begin
        failed++;
        $display("FAIL %s (R9 w=%0d) op=%0d a=%h b=%h result=%b expected=%b",
                 it.tag, it.w, it.op, it.a, it.b, gr, it.res);
      end
      tests++;
      if (gn !== it.nan) begin
        failed++;
        $display("FAIL R2 (R9 w=%0d) a=%h b=%h nan_flag=%b expected=%b",
                 it.w, it.a, it.b, gn, it.nan);
      end
    end
  end

  task automatic check_now(input string tag, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic run_width(input int w);
    logic [63:0] ones, fmax, cv[14];
    ones = (64'd1 << ew_of(w)) - 64'd1;
    fmax = (64'd1 << fw_of(w)) - 64'd1;
    cv[0]  = mk(w, 0, 0, 0);
    cv[1]  = mk(w, 1, 0, 0);
    cv[2]  = mk(w, 0, ones >> 1, 0);
    cv[3]  = mk(w, 1, ones >> 1, 0);
    cv[4]  = mk(w, 0, (ones >> 1) + 1, 0);
    cv[5]  = mk(w, 1, (ones >> 1) + 1, 0);
    cv[6]  = mk(w, 0, ones, 0);
    cv[7]  = mk(w, 1, ones, 0);
    cv[8]  = mk(w, 0, ones, 64'd1 << (fw_of(w) - 1));
    cv[9]  = mk(w, 1, ones, 64'd1);
    cv[10] = mk(w, 0, 0, 64'd1);
    cv[11] = mk(w, 1, 0, 64'd1);
    cv[12] = mk(w, 0, 0, fmax);
    cv[13] = mk(w, 0, ones - 1, fmax);
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++)
        all_ops(w, cv[i], cv[j]);
    for (int n = 0; n < 2500; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
      if (w == 32) begin ra = ra & 64'hFFFF_FFFF; rb = rb & 64'hFFFF_FFFF; end
      if ($urandom_range(0, 3) == 0) ra = ra | (ones << fw_of(w));
      if ($urandom_range(0, 3) == 0) rb = rb | (ones << fw_of(w));
      if ($urandom_range(0, 5) == 0) rb = rb ^ (64'd1 << (w - 1));
      drive(w, 3'($urandom_range(0, 7)), ra, rb);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: both operands zero, op 0 (below) -> 0, no NaN
    #2;
    check_now("R1 idle op0 w32", r32, 1'b0);
    check_now("R2 idle nan w32", n32, 1'b0);
    // R10: combinational response without a clock edge
    op32 = 3'd4; a32 = 32'h8000_0000; b32 = 32'h0000_0000;
    #1 check_now("R10 -0 eq +0 same step", r32, 1'b1);
    a32 = 32'h7FC0_0000;
    #1 check_now("R10 nan flag same step", n32, 1'b1);
    check_now("R10 eq false on nan same step", r32, 1'b0);
    a64 = 64'hBFF0_0000_0000_0000; b64 = 64'h3FF0_0000_0000_0000; op64 = 3'd0;
    #1 check_now("R10 -1 lt +1 w64 same step", r64, 1'b1);
    run_width(32);
    run_width(64);
    @(posedge clk);
    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule